// File: doc/BRIEF.md
# Two-Slot Serial Byte Receiver with Clock Stretch

This block is the receive datapath for a two-wire serial bus (I2C), as used by a target or a controller. It runs in the system clock domain. The logic around it supplies single-cycle pulses for clock rising edges and delayed clock falling edges, plus the sampled data level. Each one-cycle arm request sets the block up to receive one byte. The block shifts the byte in most significant bit first and, if enabled, pulls the data line low during the ninth clock to acknowledge. The finished byte goes to a consumer through a valid/ready pair, and the consumer takes it with a one-cycle confirm pulse.

Two bytes of storage separate the bus from the consumer. A second byte can arrive while the first is still unconfirmed. If the consumer falls further behind and a new byte is requested while both slots are occupied, the block holds the bus clock low. The hold lasts until a slot is freed. The held request then turns into an armed reception, so the bus master does not need to repeat it. A start/stop condition input aborts a byte that is in progress without losing stored bytes.

Top module: `serial_rx_twoslot`

## Requirements
- R1: While `rst_n` is low at a clock edge, both slots are emptied and `rx_valid`, `scl_hold` and `sda_drive` are cleared. After reset, `rx_ready` is high.
- R2: After an arm pulse with a free slot, the block takes one bit from `sda_in` on each `scl_rise` pulse, first bit into bit 7. After the eighth bit, the byte appears on `rx_data` with `rx_valid` high. `rx_ready` stays high while only one byte is held.
- R3: If `ack_en` is high, `sda_drive` rises on the first `scl_fall_dly` pulse after the eighth bit and falls on the next `scl_fall_dly` pulse. If `ack_en` is low, `sda_drive` stays low throughout the ninth clock.
- R4: A `rx_take` pulse with one byte held clears `rx_valid` on the next cycle. A `rx_take` pulse with nothing held changes nothing.
- R5: If a second byte completes while the first is unconfirmed, `rx_data` keeps showing the first byte, `rx_valid` stays high and `rx_ready` goes low. The store never accepts a third byte.
- R6: An arm pulse while both slots are full raises `scl_hold` on the next cycle. It stays high for as long as no `rx_take` arrives.
- R7: A `rx_take` pulse with two bytes held puts the second byte on `rx_data` in the same step. `rx_valid` stays high, `rx_ready` returns high and `scl_hold` is released. A held request becomes an armed reception with no further arm pulse.
- R8: `scl_hold` is low during the whole time bits are being shifted in.
- R9: A high `bus_cond` aborts any byte in progress and any held request. On the next cycle `sda_drive` and `scl_hold` are low, and later `scl_rise` pulses shift nothing until the next arm pulse. Bytes already stored stay available.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous reset, active low |
| bus_cond | input | 1 | start/stop condition seen; aborts reception |
| ack_en | input | 1 | acknowledge the byte when high, else NACK |
| rx_arm | input | 1 | one-cycle request to receive one byte |
| scl_rise | input | 1 | one-cycle pulse per bus clock rising edge |
| scl_fall_dly | input | 1 | one-cycle pulse per delayed bus clock falling edge |
| sda_in | input | 1 | sampled data line level |
| sda_drive | output | 1 | pull data line low (acknowledge) |
| scl_hold | output | 1 | hold bus clock low (stretch) |
| rx_valid | output | 1 | a byte is presented on rx_data |
| rx_ready | output | 1 | at least one slot is free |
| rx_data | output | 8 | oldest stored byte |
| rx_take | input | 1 | one-cycle confirm consuming rx_data |

## Verification
The assertions assume that the edge pulses are single-cycle and alternate rise then fall, as a real bus clock would produce. They also assume `rx_arm` arrives only while the receiver is idle, and `rx_take` only while `rx_valid` is high or as a deliberately ignored probe. The bench drives every pulse from one task that emits a rise and then a fall on separate cycles. It issues arm requests only between bytes. The one stray confirm it sends is an R4 check against an empty store. Aborts are placed mid-byte, in the acknowledge window and during a clock hold, to cover each phase the condition input can interrupt.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_HOLD     = 3'd1,
    PH_SHIFT    = 3'd2,
    PH_ACK_WAIT = 3'd3,
    PH_ACK      = 3'd4
  } rx_phase_e;

  // Append a new bit at the least significant end (first bit ends up on top).
  function automatic logic [7:0] shift_msb_first(input logic [7:0] cur, input logic bit_in);
    return {cur[6:0], bit_in};
  endfunction

  // Fill level after one cycle of store traffic.
  function automatic logic [1:0] next_fill(input logic [1:0] fill, input logic push, input logic pop);
    logic [1:0] f;
    f = fill;
    if (push) f = f + 2'd1;
    if (pop && fill != 2'd0) f = f - 2'd1;
    return f;
  endfunction

endpackage

// File: rtl/serial_rx_shifter.sv
module serial_rx_shifter
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              ack_en,
  input  logic              arm,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              room,
  input  logic              pop,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              sda_drive,
  output logic              scl_hold,
  output logic              shifting
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  rx_phase_e         phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sh_reg;
  logic              bit_done;

  assign shifting  = (phase == PH_SHIFT);
  assign bit_done  = shifting && scl_rise;
  assign push      = bit_done && (bit_cnt == LAST_BIT) && !abort;
  assign push_data = shift_msb_first(sh_reg, sda_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      sh_reg    <= '0;
      sda_drive <= 1'b0;
      scl_hold  <= 1'b0;
    end else if (abort) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      sda_drive <= 1'b0;
      scl_hold  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (arm) begin
            bit_cnt <= '0;
            if (room) begin
              phase <= PH_SHIFT;
            end else begin
              phase    <= PH_HOLD;
              scl_hold <= 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (pop) begin
            phase    <= PH_SHIFT;
            scl_hold <= 1'b0;
            bit_cnt  <= '0;
          end
        end
        PH_SHIFT: begin
          if (scl_rise) begin
            sh_reg <= push_data;
            if (bit_cnt == LAST_BIT) begin
              phase   <= PH_ACK_WAIT;
              bit_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        PH_ACK_WAIT: begin
          if (scl_fall) begin
            sda_drive <= ack_en;
            phase     <= PH_ACK;
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            sda_drive <= 1'b0;
            phase     <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8: no clock hold while bits are being taken in
  assert_hold_not_shifting_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !shifting);

  // R3: acknowledge drive only starts when enabled
  assert_ack_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive) |-> $past(ack_en));

  // R9: abort releases both bus outputs
  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!sda_drive && !scl_hold));

  // R6: hold persists until a confirm
  assert_hold_persist_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !pop && !abort) |=> scl_hold);

endmodule

// File: rtl/serial_rx_store.sv
module serial_rx_store
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic              valid,
  output logic              ready,
  output logic [DATA_W-1:0] dout
);

  logic [1:0]        fill;
  logic [DATA_W-1:0] slot_head;
  logic [DATA_W-1:0] slot_tail;
  logic              pop_eff;

  assign pop_eff = pop && (fill != 2'd0);
  assign valid   = (fill != 2'd0);
  assign ready   = (fill != 2'd2);
  assign dout    = slot_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill      <= 2'd0;
      slot_head <= '0;
      slot_tail <= '0;
    end else begin
      fill <= next_fill(fill, push, pop);
      if (pop_eff && fill == 2'd2) begin
        slot_head <= slot_tail;
      end else if (push && (fill == 2'd0 || (fill == 2'd1 && pop_eff))) begin
        slot_head <= din;
      end else if (push && fill == 2'd1) begin
        slot_tail <= din;
      end
    end
  end

  // R5: never a third byte
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ready);

  // R7: draining a full store leaves one byte presented and a free slot
  assert_full_pop_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !ready && !push) |=> (valid && ready));

  // R4: confirming the only byte empties the store
  assert_last_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && valid && ready && !push) |=> !valid);

  // R5: a push on a held byte keeps the presented byte
  assert_head_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && valid && ready && !pop) |=> (dout == $past(dout)));

endmodule

// File: rtl/serial_rx_twoslot.sv
module serial_rx_twoslot
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cond,
  input  logic              ack_en,
  input  logic              rx_arm,
  input  logic              scl_rise,
  input  logic              scl_fall_dly,
  input  logic              sda_in,
  output logic              sda_drive,
  output logic              scl_hold,
  output logic              rx_valid,
  output logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_take
);

  logic              push_ev;
  logic [DATA_W-1:0] push_byte;
  logic              room_ev;
  logic              shifting_ev;

  assign room_ev = rx_ready || rx_take;

  serial_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (bus_cond),
    .ack_en    (ack_en),
    .arm       (rx_arm),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall_dly),
    .sda_in    (sda_in),
    .room      (room_ev),
    .pop       (rx_take),
    .push      (push_ev),
    .push_data (push_byte),
    .sda_drive (sda_drive),
    .scl_hold  (scl_hold),
    .shifting  (shifting_ev)
  );

  serial_rx_store #(.DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ev),
    .din   (push_byte),
    .pop   (rx_take),
    .valid (rx_valid),
    .ready (rx_ready),
    .dout  (rx_data)
  );

  // R6: hold only ever raised while the store is full
  assert_hold_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> !rx_ready);

  // R9: abort never loses a stored byte
  assert_abort_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cond && rx_valid && !rx_take) |=> rx_valid);

endmodule

// File: tb/sim_serial_rx_twoslot.sv
`timescale 1ns/1ps
module sim_serial_rx_twoslot;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cond = 1'b0, ack_en = 1'b1, rx_arm = 1'b0;
  logic scl_rise = 1'b0, scl_fall_dly = 1'b0, sda_in = 1'b0, rx_take = 1'b0;
  logic sda_drive, scl_hold, rx_valid, rx_ready;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_rx_twoslot u0 (
    .clk(clk), .rst_n(rst_n), .bus_cond(bus_cond), .ack_en(ack_en),
    .rx_arm(rx_arm), .scl_rise(scl_rise), .scl_fall_dly(scl_fall_dly),
    .sda_in(sda_in), .sda_drive(sda_drive), .scl_hold(scl_hold),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_take(rx_take)
  );

  // {ack enable, byte}
  localparam logic [8:0] VEC [0:3] = '{9'h1D4, 9'h03C, 9'h100, 9'h0FF};

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic pulse_clock();
    scl_rise = 1'b1; tick(); scl_rise = 1'b0;
    scl_fall_dly = 1'b1; tick(); scl_fall_dly = 1'b0;
  endtask

  // shift eight bits and run the acknowledge clock
  task automatic shift_byte(input logic [7:0] b, input logic ack);
    ack_en = ack;
    for (int i = 7; i >= 0; i--) begin
      sda_in = b[i];
      scl_rise = 1'b1; tick(); scl_rise = 1'b0;
      chk("R8 hold while shifting", scl_hold, 0);
      scl_fall_dly = 1'b1; tick(); scl_fall_dly = 1'b0;
    end
    chk("R3 ack drive window", sda_drive, ack);
    scl_rise = 1'b1; tick(); scl_rise = 1'b0;
    chk("R3 ack held over ninth rise", sda_drive, ack);
    scl_fall_dly = 1'b1; tick(); scl_fall_dly = 1'b0;
    chk("R3 ack released", sda_drive, 0);
  endtask

  task automatic arm();
    rx_arm = 1'b1; tick(); rx_arm = 1'b0;
  endtask

  task automatic take();
    rx_take = 1'b1; tick(); rx_take = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 valid", rx_valid, 0);
    chk("R1 ready", rx_ready, 1);
    chk("R1 hold", scl_hold, 0);
    chk("R1 drive", sda_drive, 0);
    rst_n = 1'b1;
    tick();

    // R2/R3/R4 table walk
    for (int v = 0; v < 4; v++) begin
      arm();
      shift_byte(VEC[v][7:0], VEC[v][8]);
      chk("R2 data", rx_data, VEC[v][7:0]);
      chk("R2 valid", rx_valid, 1);
      chk("R2 ready single", rx_ready, 1);
      take();
      chk("R4 valid drops", rx_valid, 0);
    end

    // R4 confirm on empty is ignored
    take();
    chk("R4 empty take valid", rx_valid, 0);
    chk("R4 empty take ready", rx_ready, 1);

    // R5 two bytes queued
    arm(); shift_byte(8'hD4, 1'b1);
    arm(); shift_byte(8'h81, 1'b1);
    chk("R5 head kept", rx_data, 8'hD4);
    chk("R5 valid", rx_valid, 1);
    chk("R5 ready low", rx_ready, 0);

    // R6 stretch on arm while full
    arm();
    chk("R6 hold rises", scl_hold, 1);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R6 hold stays", scl_hold, 1);
    end
    take();
    chk("R7 second byte shown", rx_data, 8'h81);
    chk("R7 valid stays", rx_valid, 1);
    chk("R7 ready back", rx_ready, 1);
    chk("R7 hold released", scl_hold, 0);
    // R7 held request is already armed
    shift_byte(8'h03, 1'b1);
    chk("R7 armed byte queued", rx_ready, 0);
    take();
    chk("R7 queued byte shown", rx_data, 8'h03);
    chk("R7 valid after drain", rx_valid, 1);
    take();
    chk("R7 final take empties", rx_valid, 0);

    // R9 abort mid-byte
    arm();
    for (int i = 0; i < 3; i++) pulse_clock();
    bus_cond = 1'b1; tick(); bus_cond = 1'b0;
    for (int i = 0; i < 8; i++) pulse_clock();
    chk("R9 partial byte dropped", rx_valid, 0);
    arm(); shift_byte(8'h5A, 1'b1);
    chk("R9 receive after abort", rx_data, 8'h5A);

    // R9 abort in acknowledge window, stored byte kept
    arm();
    ack_en = 1'b1;
    for (int i = 0; i < 8; i++) begin sda_in = i[0]; pulse_clock(); end
    chk("R3 drive before abort", sda_drive, 1);
    bus_cond = 1'b1; tick(); bus_cond = 1'b0;
    chk("R9 drive dropped", sda_drive, 0);
    chk("R9 stored head kept", rx_data, 8'h5A);
    chk("R9 both kept", rx_ready, 0);

    // R9 abort during hold
    arm();
    chk("R6 hold again", scl_hold, 1);
    bus_cond = 1'b1; tick(); bus_cond = 1'b0;
    chk("R9 hold dropped", scl_hold, 0);
    chk("R9 valid kept", rx_valid, 1);
    take();
    chk("R9 request not revived", scl_hold, 0);
    chk("R9 second stored byte", rx_data, 8'h55);

    // R1 reset with data stored
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    chk("R1 reset empties", rx_valid, 0);
    chk("R1 reset ready", rx_ready, 1);
    chk("R1 reset drive", sda_drive, 0);
    report();
  end

endmodule